// File: doc/BRIEF.md
# Circular Reorder Window with Result Wakeup

This block is the out-of-order core of an execution pipeline in one structure. Decode writes instructions in program order into a circular window, and each instruction's slot index becomes the name of its result. Each source operand is resolved on entry. If no instruction in flight writes that register, the value comes from the architectural register file. If the youngest in-flight writer has already finished, its result is used. Otherwise the source holds the writer's slot index and waits.

The window dispatches one instruction per cycle whose two operands are present, picking the oldest one. A result bus carries a slot index, a value and an exception cause. It marks the producing slot complete and fills every source that waits on that index. The oldest slot retires once it is complete. A clean result is written to the architectural register file. A nonzero cause is reported instead, and the whole window is emptied in one cycle by pulling the allocation pointer back to the retire pointer.

Top module: `rob_window`

## Requirements
- R1: After reset the window is empty: `ins_ready` is 1, and `disp_valid`, `cmt_valid` and `exc_valid` are 0. Every architectural register reads 0.
- R2: An accepted instruction takes the slot at the allocation pointer. Slot indices are handed out in program order and wrap modulo N, starting at 0 after reset. The slot index is the tag reported on `disp_tag` and `exc_tag`.
- R3: An instruction can dispatch only while it is in the window, has not dispatched before, and has both operands present. It dispatches exactly once.
- R4: At most one instruction dispatches per cycle, and among ready instructions the oldest is chosen, counting from the retire pointer.
- R5: A result with `res_valid`=1 marks slot `res_tag` complete with `res_data` and `res_cause`. Every waiting source whose tag equals `res_tag` takes `res_data` and becomes present.
- R6: A result broadcast in the same cycle as an insertion is also taken by a source of the inserted instruction that waits on that tag.
- R7: When several in-flight instructions write a source register, the youngest of them is the producer.
- R8: When the producer has completed but not yet retired, its result is used directly and the source is present at once.
- R9: Retirement is in program order. `cmt_valid` is 1 only when the oldest slot is complete with cause 0 (`res_cause` encoding: 0 none, 1 arithmetic, 2 memory, 3 illegal). It becomes 1 the cycle after that slot's result arrives, and one slot retires per cycle.
- R10: A retiring instruction writes `cmt_data` to architectural register `cmt_dst`. A later instruction whose source register has no in-flight writer reads that value.
- R11: When N instructions are in the window, `ins_ready` is 0 and `ins_valid` is ignored. `ins_ready` returns to 1 after a retirement.
- R12: When the oldest slot completes with a nonzero cause, `exc_valid` is 1 with `exc_tag` and `exc_cause` for one cycle. In that cycle nothing retires, dispatches or is inserted. On the next cycle the window is empty, and the next slot handed out equals `exc_tag`. No flushed instruction writes the architectural register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Instruction offered by decode |
| ins_op | input | OP_W | Operation code, carried to dispatch |
| ins_dst | input | log2(NUM_AR) | Destination register |
| ins_src_a | input | log2(NUM_AR) | First source register |
| ins_src_b | input | log2(NUM_AR) | Second source register |
| ins_ready | output | 1 | Window can accept an instruction this cycle |
| disp_valid | output | 1 | An instruction is dispatched this cycle |
| disp_tag | output | log2(N) | Slot index of the dispatched instruction |
| disp_op | output | OP_W | Its operation code |
| disp_opa | output | DATA_W | Its first operand value |
| disp_opb | output | DATA_W | Its second operand value |
| res_valid | input | 1 | Result bus valid |
| res_tag | input | log2(N) | Slot whose result is on the bus |
| res_data | input | DATA_W | Result value |
| res_cause | input | 2 | Exception cause, 0 = none |
| cmt_valid | output | 1 | Oldest instruction retires this cycle |
| cmt_dst | output | log2(NUM_AR) | Register written by the retiring instruction |
| cmt_data | output | DATA_W | Value written |
| exc_valid | output | 1 | Oldest instruction faulted; window is flushed |
| exc_tag | output | log2(N) | Slot of the faulting instruction |
| exc_cause | output | 2 | Its cause |

## Verification
The bench first runs an independent chain, where each operand comes from the register file, so that insertion, dispatch, completion and retirement can be seen one at a time. It then builds patterns that separate the operand sources from one another. Two writers of one register test that the youngest is chosen. A writer finished ahead of an older unfinished one tests forwarding from a completed entry. A result that arrives in the insertion cycle tests same-cycle capture. Out-of-order completion shows that retirement waits for the oldest slot. A full window of dependents, all woken by one broadcast, shows the stall, the ignored insert and oldest-first dispatch. A fault in the oldest slot with a younger result already complete shows that the flush discards that result and restarts slot numbering at the faulting slot.

// File: rtl/rob_pkg.sv
package rob_pkg;
    typedef enum logic [1:0] {
        EXC_NONE    = 2'd0,
        EXC_ARITH   = 2'd1,
        EXC_MEM     = 2'd2,
        EXC_ILLEGAL = 2'd3
    } exc_e;
endpackage

// File: rtl/rob_find.sv
// Finds the youngest in-flight writer of a register by scanning from the oldest slot.
module rob_find #(
    parameter int N     = 8,
    parameter int IDX_W = 3,
    parameter int AR_W  = 3
) (
    input  logic [N-1:0]      use_vec,
    input  logic [N*AR_W-1:0] dst_flat,
    input  logic [AR_W-1:0]   reg_id,
    input  logic [IDX_W-1:0]  base,
    output logic              hit,
    output logic [IDX_W-1:0]  tag
);
    logic [IDX_W-1:0] pos;

    always_comb begin
        hit = 1'b0;
        tag = '0;
        pos = base;
        for (int k = 0; k < N; k++) begin
            pos = base + IDX_W'(k);
            // a later match is younger and replaces the earlier one
            if (use_vec[pos] && (dst_flat[pos*AR_W +: AR_W] == reg_id)) begin
                hit = 1'b1;
                tag = pos;
            end
        end
    end
endmodule

// File: rtl/rob_pick.sv
// Oldest-first selection of one ready slot, counting from the retire pointer.
module rob_pick #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     rdy,
    input  logic [IDX_W-1:0] base,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    logic [IDX_W-1:0] pos;

    always_comb begin
        hit = 1'b0;
        idx = base;
        pos = base;
        for (int k = N - 1; k >= 0; k--) begin
            pos = base + IDX_W'(k);
            if (rdy[pos]) begin
                hit = 1'b1;
                idx = pos;
            end
        end
    end
endmodule

// File: rtl/rob_window.sv
module rob_window
    import rob_pkg::*;
#(
    parameter int N      = 8,
    parameter int DATA_W = 16,
    parameter int OP_W   = 4,
    parameter int NUM_AR = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ins_valid,
    input  logic [OP_W-1:0]           ins_op,
    input  logic [$clog2(NUM_AR)-1:0] ins_dst,
    input  logic [$clog2(NUM_AR)-1:0] ins_src_a,
    input  logic [$clog2(NUM_AR)-1:0] ins_src_b,
    output logic                      ins_ready,
    output logic                      disp_valid,
    output logic [$clog2(N)-1:0]      disp_tag,
    output logic [OP_W-1:0]           disp_op,
    output logic [DATA_W-1:0]         disp_opa,
    output logic [DATA_W-1:0]         disp_opb,
    input  logic                      res_valid,
    input  logic [$clog2(N)-1:0]      res_tag,
    input  logic [DATA_W-1:0]         res_data,
    input  logic [1:0]                res_cause,
    output logic                      cmt_valid,
    output logic [$clog2(NUM_AR)-1:0] cmt_dst,
    output logic [DATA_W-1:0]         cmt_data,
    output logic                      exc_valid,
    output logic [$clog2(N)-1:0]      exc_tag,
    output logic [1:0]                exc_cause
);
    localparam int IDX_W = $clog2(N);
    localparam int AR_W  = $clog2(NUM_AR);
    localparam int NSRC  = 2;

    typedef struct packed {
        logic              used;
        logic              exec;
        logic              done;
        logic [OP_W-1:0]   op;
        logic              pa;
        logic [DATA_W-1:0] va;   // value when pa, else producer slot
        logic              pb;
        logic [DATA_W-1:0] vb;
        logic [AR_W-1:0]   dst;
        logic [DATA_W-1:0] data;
        exc_e              cause;
    } entry_t;

    typedef struct packed {
        entry_t [N-1:0]                  ent;
        logic [IDX_W:0]                  alloc;  // wrap bit on top
        logic [IDX_W:0]                  ret;
        logic [NUM_AR-1:0][DATA_W-1:0]   arf;
    } state_t;

    state_t st_q, st_d;

    logic [IDX_W-1:0]        alloc_idx, ret_idx, pick_idx;
    logic                    full, head_fin, flush, commit, pick_hit;
    logic [N-1:0]            use_vec, rdy_vec;
    logic [N*AR_W-1:0]       dst_flat;
    entry_t                  head;
    logic [NSRC-1:0][AR_W-1:0]   src_reg;
    logic [NSRC-1:0]             src_hit, src_p;
    logic [NSRC-1:0][IDX_W-1:0]  src_tag;
    logic [NSRC-1:0][DATA_W-1:0] src_v;

    assign alloc_idx = st_q.alloc[IDX_W-1:0];
    assign ret_idx   = st_q.ret[IDX_W-1:0];
    assign full      = (st_q.alloc[IDX_W] != st_q.ret[IDX_W]) && (alloc_idx == ret_idx);
    assign head      = st_q.ent[ret_idx];
    assign head_fin  = head.used && head.done;
    assign flush     = head_fin && (head.cause != EXC_NONE);
    assign commit    = head_fin && (head.cause == EXC_NONE);

    for (genvar g = 0; g < N; g++) begin : g_slot
        assign use_vec[g]                  = st_q.ent[g].used;
        assign dst_flat[g*AR_W +: AR_W]    = st_q.ent[g].dst;
        assign rdy_vec[g] = st_q.ent[g].used && !st_q.ent[g].exec
                            && st_q.ent[g].pa && st_q.ent[g].pb;
    end

    assign src_reg[0] = ins_src_a;
    assign src_reg[1] = ins_src_b;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        rob_find #(.N(N), .IDX_W(IDX_W), .AR_W(AR_W)) u_find (
            .use_vec (use_vec),
            .dst_flat(dst_flat),
            .reg_id  (src_reg[s]),
            .base    (ret_idx),
            .hit     (src_hit[s]),
            .tag     (src_tag[s])
        );
    end

    rob_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
        .rdy (rdy_vec),
        .base(ret_idx),
        .hit (pick_hit),
        .idx (pick_idx)
    );

    // operand resolution for the instruction being inserted
    always_comb begin
        src_p = '0;
        src_v = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (!src_hit[s]) begin
                src_p[s] = 1'b1;
                src_v[s] = st_q.arf[src_reg[s]];
            end else if (st_q.ent[src_tag[s]].done) begin
                src_p[s] = 1'b1;
                src_v[s] = st_q.ent[src_tag[s]].data;
            end else if (res_valid && (res_tag == src_tag[s])) begin
                src_p[s] = 1'b1;
                src_v[s] = res_data;
            end else begin
                src_p[s] = 1'b0;
                src_v[s] = DATA_W'(src_tag[s]);
            end
        end
    end

    assign ins_ready  = !full && !flush;
    assign disp_valid = pick_hit && !flush;
    assign disp_tag   = pick_idx;
    assign disp_op    = st_q.ent[pick_idx].op;
    assign disp_opa   = st_q.ent[pick_idx].va;
    assign disp_opb   = st_q.ent[pick_idx].vb;
    assign cmt_valid  = commit;
    assign cmt_dst    = head.dst;
    assign cmt_data   = head.data;
    assign exc_valid  = flush;
    assign exc_tag    = ret_idx;
    assign exc_cause  = head.cause;

    always_comb begin
        st_d = st_q;
        if (res_valid) begin
            for (int i = 0; i < N; i++) begin
                if (st_q.ent[i].used && !st_q.ent[i].pa
                    && (st_q.ent[i].va[IDX_W-1:0] == res_tag)) begin
                    st_d.ent[i].pa = 1'b1;
                    st_d.ent[i].va = res_data;
                end
                if (st_q.ent[i].used && !st_q.ent[i].pb
                    && (st_q.ent[i].vb[IDX_W-1:0] == res_tag)) begin
                    st_d.ent[i].pb = 1'b1;
                    st_d.ent[i].vb = res_data;
                end
            end
            if (st_q.ent[res_tag].used) begin
                st_d.ent[res_tag].done  = 1'b1;
                st_d.ent[res_tag].data  = res_data;
                st_d.ent[res_tag].cause = exc_e'(res_cause);
            end
        end
        if (disp_valid) begin
            st_d.ent[pick_idx].exec = 1'b1;
        end
        if (commit) begin
            st_d.arf[head.dst]       = head.data;
            st_d.ent[ret_idx].used   = 1'b0;
            st_d.ret                 = st_q.ret + 1'b1;
        end
        if (flush) begin
            for (int i = 0; i < N; i++) begin
                st_d.ent[i].used = 1'b0;
            end
            st_d.alloc = st_q.ret;
        end
        if (ins_valid && ins_ready) begin
            st_d.ent[alloc_idx] = '{used: 1'b1, exec: 1'b0, done: 1'b0, op: ins_op,
                                    pa: src_p[0], va: src_v[0],
                                    pb: src_p[1], vb: src_v[1],
                                    dst: ins_dst, data: '0, cause: EXC_NONE};
            st_d.alloc = st_q.alloc + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_DISP_MARKS_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |=> st_q.ent[$past(disp_tag)].exec); // R3
    AST_DISP_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |=> !(disp_valid && (disp_tag == $past(disp_tag)))); // R3
    AST_RESULT_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && use_vec[res_tag] && !flush) |=> st_q.ent[$past(res_tag)].done); // R5
    AST_RETIRE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (st_q.ret == ($past(st_q.ret) + 1'b1))); // R9
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !flush) |=> $stable(st_q.alloc)); // R11
    AST_NO_OVERFILL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.alloc - st_q.ret) <= (IDX_W+1)'(N)); // R11
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (use_vec == '0)); // R12
endmodule

// File: tb/rob_window_tb_top.sv
module rob_window_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ins_valid = 1'b0;
    logic [3:0]  ins_op = '0;
    logic [2:0]  ins_dst = '0, ins_src_a = '0, ins_src_b = '0;
    logic        ins_ready;
    logic        disp_valid;
    logic [2:0]  disp_tag;
    logic [3:0]  disp_op;
    logic [15:0] disp_opa, disp_opb;
    logic        res_valid = 1'b0;
    logic [2:0]  res_tag = '0;
    logic [15:0] res_data = '0;
    logic [1:0]  res_cause = '0;
    logic        cmt_valid;
    logic [2:0]  cmt_dst;
    logic [15:0] cmt_data;
    logic        exc_valid;
    logic [2:0]  exc_tag;
    logic [1:0]  exc_cause;

    int total = 0;
    int bad = 0;

    rob_window dut_i (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_op(ins_op), .ins_dst(ins_dst),
        .ins_src_a(ins_src_a), .ins_src_b(ins_src_b), .ins_ready(ins_ready),
        .disp_valid(disp_valid), .disp_tag(disp_tag), .disp_op(disp_op),
        .disp_opa(disp_opa), .disp_opb(disp_opb),
        .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
        .res_cause(res_cause),
        .cmt_valid(cmt_valid), .cmt_dst(cmt_dst), .cmt_data(cmt_data),
        .exc_valid(exc_valid), .exc_tag(exc_tag), .exc_cause(exc_cause)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic quiet();
        ins_valid = 1'b0;
        res_valid = 1'b0;
        res_cause = 2'd0;
    endtask

    task automatic put(input logic [3:0] op, input logic [2:0] d, input logic [2:0] a,
                       input logic [2:0] b);
        ins_valid = 1'b1; ins_op = op; ins_dst = d; ins_src_a = a; ins_src_b = b;
    endtask

    task automatic bus(input logic [2:0] t, input logic [15:0] v, input logic [1:0] c);
        res_valid = 1'b1; res_tag = t; res_data = v; res_cause = c;
    endtask

    task automatic see_disp(input string req, input logic [2:0] t, input logic [15:0] a,
                            input logic [15:0] b);
        chk({req, " disp_valid"}, 32'(disp_valid), 32'd1);
        chk({req, " disp_tag"}, 32'(disp_tag), 32'(t));
        chk({req, " disp_opa"}, 32'(disp_opa), 32'(a));
        chk({req, " disp_opb"}, 32'(disp_opb), 32'(b));
    endtask

    task automatic see_cmt(input string req, input logic [2:0] d, input logic [15:0] v);
        chk({req, " cmt_valid"}, 32'(cmt_valid), 32'd1);
        chk({req, " cmt_dst"}, 32'(cmt_dst), 32'(d));
        chk({req, " cmt_data"}, 32'(cmt_data), 32'(v));
    endtask

    task automatic t_reset();
        chk("R1 ins_ready", 32'(ins_ready), 32'd1);
        chk("R1 disp_valid", 32'(disp_valid), 32'd0);
        chk("R1 cmt_valid", 32'(cmt_valid), 32'd0);
        chk("R1 exc_valid", 32'(exc_valid), 32'd0);
    endtask

    // independent chain: tags 0 and 1, arch r1 written then read
    task automatic t_basic();
        put(4'd1, 3'd1, 3'd0, 3'd0); cyc();
        see_disp("R2 R10 first slot", 3'd0, 16'h0, 16'h0);
        chk("R2 disp_op", 32'(disp_op), 32'd1);
        quiet(); cyc();
        chk("R3 no second dispatch", 32'(disp_valid), 32'd0);
        bus(3'd0, 16'h0011, 2'd0); cyc();
        see_cmt("R9 R10 retire", 3'd1, 16'h0011);
        quiet(); cyc();
        chk("R9 retired once", 32'(cmt_valid), 32'd0);
        put(4'd2, 3'd2, 3'd1, 3'd0); cyc();
        see_disp("R10 arch read", 3'd1, 16'h0011, 16'h0);
        quiet(); cyc();
        bus(3'd1, 16'h0022, 2'd0); cyc();
        quiet(); cyc();
    endtask

    // youngest writer, wakeup, out-of-order completion, in-order retire
    task automatic t_rename();
        put(4'd3, 3'd3, 3'd0, 3'd0); cyc();
        see_disp("R2 tag2", 3'd2, 16'h0, 16'h0);
        put(4'd4, 3'd3, 3'd0, 3'd0); cyc();
        see_disp("R4 tag3", 3'd3, 16'h0, 16'h0);
        put(4'd5, 3'd4, 3'd3, 3'd3); cyc();
        chk("R3 waiting not dispatched", 32'(disp_valid), 32'd0);
        chk("R9 nothing complete", 32'(cmt_valid), 32'd0);
        quiet(); bus(3'd3, 16'h0033, 2'd0); cyc();
        see_disp("R5 R7 wakeup youngest", 3'd4, 16'h0033, 16'h0033);
        chk("R9 head not done", 32'(cmt_valid), 32'd0);
        bus(3'd2, 16'h0044, 2'd0); cyc();
        see_cmt("R9 oldest first", 3'd3, 16'h0044);
        bus(3'd4, 16'h0055, 2'd0); cyc();
        see_cmt("R9 second", 3'd3, 16'h0033);
        quiet(); cyc();
        see_cmt("R9 third", 3'd4, 16'h0055);
        cyc();
        chk("R9 drained", 32'(cmt_valid), 32'd0);
    endtask

    // completed-not-retired forwarding and same-cycle capture
    task automatic t_forward();
        put(4'd6, 3'd6, 3'd0, 3'd0); cyc();
        see_disp("R2 tag5", 3'd5, 16'h0, 16'h0);
        put(4'd7, 3'd7, 3'd0, 3'd0); cyc();
        see_disp("R2 tag6", 3'd6, 16'h0, 16'h0);
        quiet(); cyc();
        chk("R3 idle", 32'(disp_valid), 32'd0);
        bus(3'd6, 16'h0066, 2'd0); cyc();
        chk("R9 younger done waits", 32'(cmt_valid), 32'd0);
        quiet();
        put(4'd8, 3'd2, 3'd7, 3'd6); bus(3'd5, 16'h0077, 2'd0); cyc();
        see_disp("R6 R8 operands", 3'd7, 16'h0066, 16'h0077);
        see_cmt("R9 head", 3'd6, 16'h0077);
        quiet(); cyc();
        see_cmt("R9 next", 3'd7, 16'h0066);
        bus(3'd7, 16'h0088, 2'd0); cyc();
        see_cmt("R9 last", 3'd2, 16'h0088);
        quiet(); cyc();
        chk("R9 empty", 32'(cmt_valid), 32'd0);
    endtask

    // full window of dependents, ignored insert, oldest-first wake
    task automatic t_full();
        put(4'd0, 3'd5, 3'd0, 3'd0); cyc();
        see_disp("R2 wrap to 0", 3'd0, 16'h0, 16'h0);
        for (int k = 1; k < 8; k++) begin
            put(4'(k), 3'd4, 3'd5, 3'd0); cyc();
        end
        quiet();
        chk("R11 full", 32'(ins_ready), 32'd0);
        chk("R3 all waiting", 32'(disp_valid), 32'd0);
        put(4'd9, 3'd3, 3'd0, 3'd0); cyc();
        chk("R11 still full", 32'(ins_ready), 32'd0);
        chk("R11 insert ignored", 32'(disp_valid), 32'd0);
        quiet(); bus(3'd0, 16'h0010, 2'd0); cyc();
        quiet();
        for (int k = 1; k < 8; k++) begin
            see_disp("R4 oldest ready", 3'(k), 16'h0010, 16'h0);
            if (k == 2) chk("R11 space after retire", 32'(ins_ready), 32'd1);
            cyc();
        end
    endtask

    // fault in the oldest slot flushes everything
    task automatic t_fault();
        bus(3'd2, 16'h0020, 2'd0); cyc();
        chk("R9 wait for oldest", 32'(cmt_valid), 32'd0);
        chk("R12 no fault yet", 32'(exc_valid), 32'd0);
        bus(3'd1, 16'h0021, 2'd1); cyc();
        chk("R12 exc_valid", 32'(exc_valid), 32'd1);
        chk("R12 exc_tag", 32'(exc_tag), 32'd1);
        chk("R12 exc_cause", 32'(exc_cause), 32'd1);
        chk("R12 no retire", 32'(cmt_valid), 32'd0);
        chk("R12 no insert", 32'(ins_ready), 32'd0);
        quiet(); cyc();
        chk("R12 fault once", 32'(exc_valid), 32'd0);
        chk("R12 ready again", 32'(ins_ready), 32'd1);
        chk("R12 nothing left", 32'(disp_valid), 32'd0);
        chk("R12 nothing retires", 32'(cmt_valid), 32'd0);
        put(4'd9, 3'd3, 3'd4, 3'd2); cyc();
        see_disp("R12 slot reuse, r4 untouched", 3'd1, 16'h0055, 16'h0088);
        quiet(); cyc();
        bus(3'd1, 16'h0099, 2'd0); cyc();
        see_cmt("R12 after flush", 3'd3, 16'h0099);
        quiet(); cyc();
    endtask

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_rename();
        t_forward();
        t_full();
        t_fault();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule